// File: doc/BRIEF.md
# Byte-Serial 16-bit Register Read Bridge

This block places a bank of 16-bit result registers behind an 8-bit read bus. A reader fetches each 16-bit value as two byte reads. The pair cannot tear, because the second half comes from a snapshot and never from the live register.

A high-byte read returns the upper half of the addressed register. In the same cycle it copies that register's lower half into one shared 8-bit hold latch. A later low-byte read of any register returns the hold latch and not the live lower half. A reader may stop after the high byte. A producer, such as a converter, updates whole 16-bit registers through a separate write port, and that port never touches the hold latch.

Read data is registered. It appears on `rd_data_o` one clock after the strobe and stays there until the next read.

Top module: `bytewise_read_bridge`

## Requirements
- R1: While `rst_ni` is low, and until the first read after reset, `rd_data_o`, the hold latch and every result register are zero.
- R2: A read strobe with `rd_addr_i[0]` = 0 (high byte) and `rd_addr_i[2:1]` = n puts bits [15:8] of register n on `rd_data_o` one clock later.
- R3: The same high-byte read loads bits [7:0] of register n into the hold latch. A following low-byte read returns them. For example, register value 0xAA40 reads as 0xAA and then 0x40.
- R4: A read strobe with `rd_addr_i[0]` = 1 (low byte) returns the hold latch one clock later, whatever the live lower half of the addressed register holds.
- R5: A low-byte read with no high-byte read before it returns whatever the hold latch last held. After reset that value is 0x00.
- R6: One hold latch serves all registers. A high-byte read of register m, placed between a high-byte read of n and the low-byte read of n, makes that low-byte read return register m's lower half.
- R7: When `wr_en_i` is high, register `wr_idx_i` takes `wr_data_i` at the clock edge. The hold latch does not change, so a write between the two reads of a pair does not alter the low byte returned.
- R8: While `rd_en_i` is low, `rd_data_o` holds its last value, even while writes occur.
- R9: When a read and a write to the same register fall in the same cycle, the read returns the register's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Producer write enable |
| wr_idx_i | input | 2 | Index of the register to write |
| wr_data_i | input | 16 | Producer write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 3 | Byte address: [2:1] register index, [0] byte select (0 high, 1 low) |
| rd_data_o | output | 8 | Registered read data |

## Verification
The assertions assume that `rd_en_i`, `rd_addr_i`, `wr_en_i`, `wr_idx_i` and `wr_data_i` are known and settled at every rising edge after reset. The bench drives every input on the falling clock edge and returns the strobes to zero after each operation, so this assumption always holds. The sweeps use only the four legal indices, and they deliberately include low-byte reads with no high byte before them, interleaved pairs, and reads that coincide with writes.

// File: rtl/bytewise_read_bridge_pkg.sv
package bytewise_read_bridge_pkg;
  typedef enum logic {
    BYTE_HI = 1'b0,
    BYTE_LO = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/bwr_reg_bank.sv
module bwr_reg_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    q <= wr_data_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/bwr_hold_latch.sv
module bwr_hold_latch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] d_i,
  output logic [BYTE_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/bwr_read_port.sv
module bwr_read_port
  import bytewise_read_bridge_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int BYTE_W   = 8,
  localparam int DATA_W  = 2 * BYTE_W,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_en_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  input  logic [BYTE_W-1:0]          hold_i,
  output logic                       cap_en_o,
  output logic [BYTE_W-1:0]          cap_data_o,
  output logic [BYTE_W-1:0]          rd_data_o
);
  logic [IDX_W-1:0]  idx;
  byte_sel_e         sel;
  logic [DATA_W-1:0] word;
  logic [BYTE_W-1:0] next_byte;

  assign idx  = rd_addr_i[ADDR_W-1:1];
  assign sel  = byte_sel_e'(rd_addr_i[0]);
  assign word = regs_i[idx*DATA_W +: DATA_W];

  assign cap_en_o   = rd_en_i && (sel == BYTE_HI);
  assign cap_data_o = word[BYTE_W-1:0];
  assign next_byte  = (sel == BYTE_HI) ? word[DATA_W-1:BYTE_W] : hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= next_byte;
  end
endmodule

// File: rtl/bytewise_read_bridge.sv
module bytewise_read_bridge #(
  parameter int NUM_REGS = 4,
  parameter int BYTE_W   = 8,
  localparam int DATA_W  = 2 * BYTE_W,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [NUM_REGS*DATA_W-1:0] regs;
  logic                       cap_en;
  logic [BYTE_W-1:0]          cap_data;
  logic [BYTE_W-1:0]          hold_q;

  bwr_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i, .regs_o(regs)
  );

  bwr_hold_latch #(.BYTE_W(BYTE_W)) u_hold (
    .clk_i, .rst_ni, .load_i(cap_en), .d_i(cap_data), .q_o(hold_q)
  );

  bwr_read_port #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) u_rd (
    .clk_i, .rst_ni, .rd_en_i, .rd_addr_i, .regs_i(regs), .hold_i(hold_q),
    .cap_en_o(cap_en), .cap_data_o(cap_data), .rd_data_o
  );
endmodule

// File: rtl/bytewise_read_bridge_chk.sv
module bytewise_read_bridge_chk #(
  parameter int NUM_REGS = 4,
  parameter int BYTE_W   = 8,
  localparam int DATA_W  = 2 * BYTE_W,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int ADDR_W  = IDX_W + 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic [IDX_W-1:0]           wr_idx_i,
  input logic [DATA_W-1:0]          wr_data_i,
  input logic                       rd_en_i,
  input logic [ADDR_W-1:0]          rd_addr_i,
  input logic [BYTE_W-1:0]          rd_data_o,
  input logic [NUM_REGS*DATA_W-1:0] regs,
  input logic [BYTE_W-1:0]          hold_q
);
  logic [DATA_W-1:0] sel_word;
  logic              hi_rd, lo_rd;
  assign sel_word = regs[rd_addr_i[ADDR_W-1:1]*DATA_W +: DATA_W];
  assign hi_rd    = rd_en_i && !rd_addr_i[0];
  assign lo_rd    = rd_en_i &&  rd_addr_i[0];

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni |-> (rd_data_o == '0 && hold_q == '0 && regs == '0)));

  assert_high_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_rd |=> rd_data_o == $past(sel_word[DATA_W-1:BYTE_W]));

  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_rd |=> hold_q == $past(sel_word[BYTE_W-1:0]));

  assert_low_from_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_rd |=> rd_data_o == $past(hold_q));

  assert_hold_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_rd |=> $stable(hold_q));

  assert_idle_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wr
    assert_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_idx_i == IDX_W'(g)) |=> regs[g*DATA_W +: DATA_W] == $past(wr_data_i));
  end
endmodule

bind bytewise_read_bridge bytewise_read_bridge_chk #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i, .rd_en_i, .rd_addr_i, .rd_data_o,
  .regs(regs), .hold_q(hold_q)
);

// File: tb/sim_bytewise_read_bridge.sv
`timescale 1ns/1ps
module sim_bytewise_read_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_idx_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] m_reg [4];
  logic [7:0]  m_hold;
  logic [7:0]  m_out;

  always #4 clk_i = ~clk_i;

  bytewise_read_bridge u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: rd_data_o=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, model update, sample at next negedge
  task automatic step(input string tag, input logic re, input logic [2:0] a,
                      input logic we, input logic [1:0] wi, input logic [15:0] wd);
    rd_en_i = re; rd_addr_i = a; wr_en_i = we; wr_idx_i = wi; wr_data_i = wd;
    if (re) begin
      if (!a[0]) begin
        m_out  = m_reg[a[2:1]][15:8];
        m_hold = m_reg[a[2:1]][7:0];
      end else begin
        m_out = m_hold;
      end
    end
    if (we) m_reg[wi] = wd;
    @(posedge clk_i);
    @(negedge clk_i);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
    chk(tag, rd_data_o, m_out);
  endtask

  task automatic wr(input logic [1:0] i, input logic [15:0] d);
    step("R7", 1'b0, 3'd0, 1'b1, i, d);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: rd_data_o=%02h expected=completion", rd_data_o);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    m_hold = '0; m_out = '0;
    repeat (3) @(negedge clk_i);
    chk("R1", rd_data_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", rd_data_o, 8'h00);

    // R5/R1: low reads before any high read return the reset latch value
    for (int i = 0; i < 4; i++) step("R5", 1'b1, 3'(i*2+1), 1'b0, 2'd0, 16'h0);
    for (int i = 0; i < 4; i++) step("R1", 1'b1, 3'(i*2), 1'b0, 2'd0, 16'h0);

    // R3 worked example
    wr(2'd0, 16'hAA40);
    step("R2", 1'b1, 3'd0, 1'b0, 2'd0, 16'h0);
    chk("R2", rd_data_o, 8'hAA);
    step("R3", 1'b1, 3'd1, 1'b0, 2'd0, 16'h0);
    chk("R3", rd_data_o, 8'h40);

    // sweep: patterns over all registers and both bytes
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 4; i++)
        wr(2'(i), 16'((p * 16'h1357) ^ (i * 16'h2468) ^ 16'h0F0F));
      for (int i = 0; i < 4; i++) begin
        step("R2", 1'b1, 3'(i*2), 1'b0, 2'd0, 16'h0);
        step("R3", 1'b1, 3'(i*2+1), 1'b0, 2'd0, 16'h0);
      end
    end

    // R4/R7: update between the two reads does not change the low byte
    wr(2'd2, 16'h1234);
    step("R2", 1'b1, 3'd4, 1'b0, 2'd0, 16'h0);
    wr(2'd2, 16'hBEEF);
    step("R4", 1'b1, 3'd5, 1'b0, 2'd0, 16'h0);
    chk("R4", rd_data_o, 8'h34);
    step("R7", 1'b1, 3'd4, 1'b0, 2'd0, 16'h0);
    chk("R7", rd_data_o, 8'hBE);

    // R6: interleaved high reads share one latch
    wr(2'd0, 16'h11A1);
    wr(2'd1, 16'h22B2);
    step("R2", 1'b1, 3'd0, 1'b0, 2'd0, 16'h0);
    step("R2", 1'b1, 3'd2, 1'b0, 2'd0, 16'h0);
    step("R6", 1'b1, 3'd1, 1'b0, 2'd0, 16'h0);
    chk("R6", rd_data_o, 8'hB2);

    // R8: idle cycles with writes keep the output
    for (int k = 0; k < 6; k++) begin
      step("R8", 1'b0, 3'd0, 1'b1, 2'(k), 16'(16'hC3C3 + k));
      chk("R8", rd_data_o, 8'hB2);
    end

    // R9: same-cycle high read and write of one register
    wr(2'd3, 16'h5A6B);
    step("R9", 1'b1, 3'd6, 1'b1, 2'd3, 16'h7C8D);
    chk("R9", rd_data_o, 8'h5A);
    step("R9", 1'b1, 3'd7, 1'b0, 2'd0, 16'h0);
    chk("R9", rd_data_o, 8'h6B);
    step("R9", 1'b1, 3'd6, 1'b0, 2'd0, 16'h0);
    chk("R9", rd_data_o, 8'h7C);

    // mixed pseudo-random traffic against the model
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[0] && !lf[1])     step("R2", 1'b1, {lf[3:2], 1'b0}, lf[4], lf[6:5], {lf[7:0], lf[15:8]});
      else if (lf[0])          step("R4", 1'b1, {lf[3:2], 1'b1}, lf[4], lf[6:5], {lf[7:0], lf[15:8]});
      else                     step("R8", 1'b0, 3'd0, lf[4], lf[6:5], {lf[7:0], lf[15:8]});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule